// File: doc/BRIEF.md
# Display-Link PHY Control Register Bank with Per-Bit Write Enables

This block holds the static configuration of a multi-lane display-link transmitter PHY. It has twelve 16-bit control registers and two read-only status words, all reached through a plain register bus with single-cycle read and write strobes and 32-bit data. Every control field is driven straight out as a parallel output: lane idle and power-down, PLL power-down and dividers, link rate, termination, per-lane swing, pre-emphasis and amplitude scale, spread-spectrum settings, and the aux channel settings.

A write never needs a read-modify-write. The upper half of the write word is a per-bit enable for the lower half. Only the enabled bits take the new data, so software can change one field while a second agent owns the neighbouring bits. Bits that no field uses are not built. They read as zero and cannot be set.

Reads are registered. The word appears on `rdata` one cycle after the read strobe and stays there until the next read. A read and a write in the same cycle to the same register return the contents from before the write.

Top module: `lphy_ctl_bank`

## Requirements
- R1: Synchronous active-high reset sets register 0x00 to 0x0FF1 (all four lane-idle bits 11:8, all four lane power-down bits 7:4 and PLL power-down bit 0 at 1) and every other control register to 0x0000. The outputs follow these values.
- R2: A write to control offset 4·n (n = 0..11) stores `wdata[b]` into bit b (b = 0..15) exactly when `wdata[16+b]` is 1. Every other bit keeps its value.
- R3: A write whose enable half `wdata[31:16]` is zero changes no register and no output.
- R4: Only these bits are implemented and writable: 0x00 0x0FF3, 0x04 0x7FFF, 0x08 0x073F, 0x0C 0xFFFF, 0x10 0x7777, 0x14 0x03FF, 0x18 0xFBFF, 0x1C/0x20/0x24 0xFFFF, 0x28 0x0037, 0x2C 0x7F77. All other bits read 0 at all times.
- R5: A read returns the 16-bit content in `rdata[15:0]` with `rdata[31:16]` at zero. The word appears in the cycle after `rd_en` and holds while `rd_en` is low.
- R6: Offset 0x30 reads `pll_ready` in bit 0 and zero in bits 15:1.
- R7: Offset 0x34 reads the 16-bit `phy_status` input.
- R8: Writes to 0x30, 0x34, to any offset above 0x34, or to an address with bits 1:0 not zero change nothing. Reads of unmapped or misaligned addresses return zero.
- R9: The field outputs follow the registers in the cycle after the write that changes them:
  - 0x00: `tx_idle` = 11:8, `tx_pd` = 7:4, `iddq_en` = 1, `pll_pd` = 0.
  - 0x04: `pll_div` = 14:0.
  - 0x08: `tx_term` = 10:8, `link_rate` = 5:4, `ref_div` = 3:0.
  - 0x0C: `tx_emp` lane l = 4l+3:4l.
  - 0x10: `tx_amp` lane l = 4l+2:4l, output slice 3l+2:3l.
  - 0x14: `tx_mode` = 9:8, `tx_amp_scale` lane l = 2l+1:2l.
  - 0x18: `ssc_depth` = 15:12, `ssc_en` = 11, `ssc_cnt` = 9:0.
  - 0x1C: `spare_ctl`.
  - 0x20: `pll_ctl_hi`.
  - 0x24: `tx_ctl`.
  - 0x28: `aux_rcv_pd_sel` = 5, `aux_drv_pd_sel` = 4, `aux_idle` = 2, `aux_rcv_pd` = 1, `aux_drv_pd` = 0.
  - 0x2C: `aux_vcm` = 14:12, `aux_mode` = 11:10, `aux_amp_scale` = 9:8, `aux_amp` = 6:4, `aux_term` = 2:0.
- R10: When `rd_en` and `wr_en` are both high for the same register, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Enable mask in 31:16, data in 15:0 |
| rdata | output | 32 | Registered read data |
| pll_ready | input | 1 | PLL lock indication |
| phy_status | input | 16 | Raw PHY status word |
| tx_idle | output | 4 | Per-lane idle |
| tx_pd | output | 4 | Per-lane transmit power-down |
| iddq_en | output | 1 | Quiescent-current test enable |
| pll_pd | output | 1 | PLL power-down |
| pll_div | output | 15 | PLL feedback divider |
| tx_term | output | 3 | Transmit termination |
| link_rate | output | 2 | Link-rate select |
| ref_div | output | 4 | Reference divider |
| tx_emp | output | 16 | Per-lane pre-emphasis, 4 bits per lane |
| tx_amp | output | 12 | Per-lane swing, 3 bits per lane |
| tx_amp_scale | output | 8 | Per-lane amplitude scale, 2 bits per lane |
| tx_mode | output | 2 | Transmit mode |
| ssc_depth | output | 4 | Spread-spectrum depth |
| ssc_en | output | 1 | Spread-spectrum enable |
| ssc_cnt | output | 10 | Spread-spectrum count |
| spare_ctl | output | 16 | General control word |
| pll_ctl_hi | output | 16 | PLL control word |
| tx_ctl | output | 16 | Transmit control word |
| aux_rcv_pd_sel | output | 1 | Aux receiver power-down source select |
| aux_drv_pd_sel | output | 1 | Aux driver power-down source select |
| aux_idle | output | 1 | Aux idle |
| aux_rcv_pd | output | 1 | Aux receiver power-down |
| aux_drv_pd | output | 1 | Aux driver power-down |
| aux_vcm | output | 3 | Aux receiver common mode |
| aux_mode | output | 2 | Aux mode |
| aux_amp_scale | output | 2 | Aux amplitude scale |
| aux_amp | output | 3 | Aux amplitude |
| aux_term | output | 3 | Aux termination |

## Verification
The bench walks a single enable bit across every bit of every control register, once with ones and once with zeros as data. It then sends random data and mask pairs, including an all-zero mask and a full mask.

Each error in the design shows up in a specific way:
- A design that ignores the mask, or applies it to the wrong half, corrupts neighbouring bits.
- A design that stores unimplemented bits reads back non-zero where R4 demands zero.
- A decoder that ignores the low address bits, or wraps at the top of the map, lets writes to 0x01 or 0x38 alias onto registers. After such writes the bench reads back all twelve registers.
- A read path that samples after the write, instead of before it, fails the same-cycle read-and-write case.

// File: rtl/lphy_pkg.sv
package lphy_pkg;

    localparam int HALF_W   = 16;
    localparam int NUM_CTRL = 12;
    localparam int NUM_STAT = 2;
    localparam int LANES    = 4;

    // Bits physically built in each control register (R4)
    function automatic logic [HALF_W-1:0] impl_mask(input int idx);
        case (idx)
            0:       return 16'h0FF3;
            1:       return 16'h7FFF;
            2:       return 16'h073F;
            3:       return 16'hFFFF;
            4:       return 16'h7777;
            5:       return 16'h03FF;
            6:       return 16'hFBFF;
            7:       return 16'hFFFF;
            8:       return 16'hFFFF;
            9:       return 16'hFFFF;
            10:      return 16'h0037;
            11:      return 16'h7F77;
            default: return 16'h0000;
        endcase
    endfunction

    // Reset contents: lanes idle and powered down, PLL powered down
    function automatic logic [HALF_W-1:0] reset_val(input int idx);
        return (idx == 0) ? 16'h0FF1 : 16'h0000;
    endfunction

    typedef struct packed {
        logic [LANES-1:0]        tx_idle;
        logic [LANES-1:0]        tx_pd;
        logic                    iddq_en;
        logic                    pll_pd;
        logic [14:0]             pll_div;
        logic [2:0]              tx_term;
        logic [1:0]              link_rate;
        logic [3:0]              ref_div;
        logic [LANES-1:0][3:0]   tx_emp;
        logic [LANES-1:0][2:0]   tx_amp;
        logic [LANES-1:0][1:0]   tx_amp_scale;
        logic [1:0]              tx_mode;
        logic [3:0]              ssc_depth;
        logic                    ssc_en;
        logic [9:0]              ssc_cnt;
        logic [15:0]             spare_ctl;
        logic [15:0]             pll_ctl_hi;
        logic [15:0]             tx_ctl;
        logic                    aux_rcv_pd_sel;
        logic                    aux_drv_pd_sel;
        logic                    aux_idle;
        logic                    aux_rcv_pd;
        logic                    aux_drv_pd;
        logic [2:0]              aux_vcm;
        logic [1:0]              aux_mode;
        logic [1:0]              aux_amp_scale;
        logic [2:0]              aux_amp;
        logic [2:0]              aux_term;
    } lphy_ctl_t;

    typedef struct packed {
        logic [2*HALF_W-1:0] rdata;
    } bank_state_t;

endpackage

// File: rtl/lphy_addr_dec.sv
module lphy_addr_dec #(
    parameter int ADDR_W   = 8,
    parameter int NUM_CTRL = 12,
    parameter int NUM_STAT = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_CTRL-1:0] ctrl_sel,
    output logic [NUM_STAT-1:0] stat_sel
);
    localparam int IDX_W    = ADDR_W - 2;
    localparam int STAT_IDX = NUM_CTRL;

    logic             aligned;
    logic [IDX_W-1:0] word_idx;

    assign aligned  = (addr[1:0] == 2'b00);
    assign word_idx = addr[ADDR_W-1:2];

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
        assign ctrl_sel[i] = aligned && (word_idx == IDX_W'(i));
    end

    for (genvar j = 0; j < NUM_STAT; j++) begin : g_stat
        assign stat_sel[j] = aligned && (word_idx == IDX_W'(STAT_IDX + j));
    end
endmodule

// File: rtl/lphy_mask_reg.sv
module lphy_mask_reg #(
    parameter int          W    = 16,
    parameter logic [W-1:0] RST  = '0,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [2*W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;
    logic [W-1:0] bit_en;
    logic [W-1:0] bit_val;

    assign bit_en  = wdata[2*W-1:W];
    assign bit_val = wdata[W-1:0];

    always_comb begin
        q_d = q_q;
        if (we) begin
            q_d = ((q_q & ~bit_en) | (bit_val & bit_en)) & IMPL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q <= RST;
        end else begin
            q_q <= q_d;
        end
    end

    assign q = q_q;
endmodule

// File: rtl/lphy_field_map.sv
module lphy_field_map
    import lphy_pkg::*;
(
    input  logic [NUM_CTRL-1:0][HALF_W-1:0] regs,
    output lphy_ctl_t                       ctl
);
    logic unused_bits;

    always_comb begin
        ctl = '0;
        ctl.tx_idle   = regs[0][11:8];
        ctl.tx_pd     = regs[0][7:4];
        ctl.iddq_en   = regs[0][1];
        ctl.pll_pd    = regs[0][0];
        ctl.pll_div   = regs[1][14:0];
        ctl.tx_term   = regs[2][10:8];
        ctl.link_rate = regs[2][5:4];
        ctl.ref_div   = regs[2][3:0];
        for (int l = 0; l < LANES; l++) begin
            ctl.tx_emp[l]       = regs[3][4*l +: 4];
            ctl.tx_amp[l]       = regs[4][4*l +: 3];
            ctl.tx_amp_scale[l] = regs[5][2*l +: 2];
        end
        ctl.tx_mode        = regs[5][9:8];
        ctl.ssc_depth      = regs[6][15:12];
        ctl.ssc_en         = regs[6][11];
        ctl.ssc_cnt        = regs[6][9:0];
        ctl.spare_ctl      = regs[7];
        ctl.pll_ctl_hi     = regs[8];
        ctl.tx_ctl         = regs[9];
        ctl.aux_rcv_pd_sel = regs[10][5];
        ctl.aux_drv_pd_sel = regs[10][4];
        ctl.aux_idle       = regs[10][2];
        ctl.aux_rcv_pd     = regs[10][1];
        ctl.aux_drv_pd     = regs[10][0];
        ctl.aux_vcm        = regs[11][14:12];
        ctl.aux_mode       = regs[11][11:10];
        ctl.aux_amp_scale  = regs[11][9:8];
        ctl.aux_amp        = regs[11][6:4];
        ctl.aux_term       = regs[11][2:0];
    end

    assign unused_bits = ^{regs[0][15:12], regs[0][3:2], regs[1][15],
                           regs[2][15:11], regs[2][7:6],
                           regs[4][15], regs[4][11], regs[4][7], regs[4][3],
                           regs[5][15:10], regs[6][10], regs[10][15:6],
                           regs[10][3], regs[11][15], regs[11][7], regs[11][3]};
endmodule

// File: rtl/lphy_ctl_bank.sv
module lphy_ctl_bank
    import lphy_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        pll_ready,
    input  logic [15:0] phy_status,
    output logic [3:0]  tx_idle,
    output logic [3:0]  tx_pd,
    output logic        iddq_en,
    output logic        pll_pd,
    output logic [14:0] pll_div,
    output logic [2:0]  tx_term,
    output logic [1:0]  link_rate,
    output logic [3:0]  ref_div,
    output logic [15:0] tx_emp,
    output logic [11:0] tx_amp,
    output logic [7:0]  tx_amp_scale,
    output logic [1:0]  tx_mode,
    output logic [3:0]  ssc_depth,
    output logic        ssc_en,
    output logic [9:0]  ssc_cnt,
    output logic [15:0] spare_ctl,
    output logic [15:0] pll_ctl_hi,
    output logic [15:0] tx_ctl,
    output logic        aux_rcv_pd_sel,
    output logic        aux_drv_pd_sel,
    output logic        aux_idle,
    output logic        aux_rcv_pd,
    output logic        aux_drv_pd,
    output logic [2:0]  aux_vcm,
    output logic [1:0]  aux_mode,
    output logic [1:0]  aux_amp_scale,
    output logic [2:0]  aux_amp,
    output logic [2:0]  aux_term
);
    logic [NUM_CTRL-1:0]             ctrl_sel;
    logic [NUM_STAT-1:0]             stat_sel;
    logic [NUM_CTRL-1:0][HALF_W-1:0] ctl_regs;
    logic [HALF_W-1:0]               rd_word;
    lphy_ctl_t                       ctl;
    bank_state_t                     st_d, st_q;

    lphy_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_CTRL (NUM_CTRL),
        .NUM_STAT (NUM_STAT)
    ) u_dec (
        .addr     (addr),
        .ctrl_sel (ctrl_sel),
        .stat_sel (stat_sel)
    );

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
        lphy_mask_reg #(
            .W    (HALF_W),
            .RST  (reset_val(i)),
            .IMPL (impl_mask(i))
        ) u_reg (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_en && ctrl_sel[i]),
            .wdata (wdata),
            .q     (ctl_regs[i])
        );
    end

    lphy_field_map u_map (
        .regs (ctl_regs),
        .ctl  (ctl)
    );

    // Read path samples current contents, so a same-cycle write is not seen
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (ctrl_sel[i]) rd_word = rd_word | ctl_regs[i];
        end
        if (stat_sel[0]) rd_word = rd_word | {{(HALF_W-1){1'b0}}, pll_ready};
        if (stat_sel[1]) rd_word = rd_word | phy_status;

        st_d = st_q;
        if (rd_en) begin
            st_d.rdata = {{HALF_W{1'b0}}, rd_word};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata          = st_q.rdata;
    assign tx_idle        = ctl.tx_idle;
    assign tx_pd          = ctl.tx_pd;
    assign iddq_en        = ctl.iddq_en;
    assign pll_pd         = ctl.pll_pd;
    assign pll_div        = ctl.pll_div;
    assign tx_term        = ctl.tx_term;
    assign link_rate      = ctl.link_rate;
    assign ref_div        = ctl.ref_div;
    assign tx_emp         = ctl.tx_emp;
    assign tx_amp         = ctl.tx_amp;
    assign tx_amp_scale   = ctl.tx_amp_scale;
    assign tx_mode        = ctl.tx_mode;
    assign ssc_depth      = ctl.ssc_depth;
    assign ssc_en         = ctl.ssc_en;
    assign ssc_cnt        = ctl.ssc_cnt;
    assign spare_ctl      = ctl.spare_ctl;
    assign pll_ctl_hi     = ctl.pll_ctl_hi;
    assign tx_ctl         = ctl.tx_ctl;
    assign aux_rcv_pd_sel = ctl.aux_rcv_pd_sel;
    assign aux_drv_pd_sel = ctl.aux_drv_pd_sel;
    assign aux_idle       = ctl.aux_idle;
    assign aux_rcv_pd     = ctl.aux_rcv_pd;
    assign aux_drv_pd     = ctl.aux_drv_pd;
    assign aux_vcm        = ctl.aux_vcm;
    assign aux_mode       = ctl.aux_mode;
    assign aux_amp_scale  = ctl.aux_amp_scale;
    assign aux_amp        = ctl.aux_amp;
    assign aux_term       = ctl.aux_term;
endmodule

// File: rtl/lphy_ctl_bank_chk.sv
module lphy_ctl_bank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              pll_ready,
    input logic [3:0]        tx_idle,
    input logic [3:0]        tx_pd,
    input logic              pll_pd,
    input logic [14:0]       pll_div,
    input logic [9:0]        ssc_cnt
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_idle == 4'hF && tx_pd == 4'hF && pll_pd && pll_div == 15'd0));

    // R3
    zero_mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[31:16] == 16'h0) |=> ($stable(tx_idle) && $stable(pll_div) && $stable(ssc_cnt)));

    // R8
    no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(tx_pd) && $stable(pll_pd) && $stable(pll_div) && $stable(ssc_cnt)));

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rdata[31:16] == 16'h0);

    // R5
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R6
    pll_status_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(48)) |=> (rdata == {31'b0, $past(pll_ready)}));
endmodule

bind lphy_ctl_bank lphy_ctl_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_lphy_ctl_bank.sv
module sim_lphy_ctl_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pll_ready = 1'b0;
    logic [15:0] phy_status = '0;
    logic [3:0]  tx_idle, tx_pd;
    logic        iddq_en, pll_pd;
    logic [14:0] pll_div;
    logic [2:0]  tx_term;
    logic [1:0]  link_rate;
    logic [3:0]  ref_div;
    logic [15:0] tx_emp;
    logic [11:0] tx_amp;
    logic [7:0]  tx_amp_scale;
    logic [1:0]  tx_mode;
    logic [3:0]  ssc_depth;
    logic        ssc_en;
    logic [9:0]  ssc_cnt;
    logic [15:0] spare_ctl, pll_ctl_hi, tx_ctl;
    logic        aux_rcv_pd_sel, aux_drv_pd_sel, aux_idle, aux_rcv_pd, aux_drv_pd;
    logic [2:0]  aux_vcm;
    logic [1:0]  aux_mode, aux_amp_scale;
    logic [2:0]  aux_amp, aux_term;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] model [12];
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    lphy_ctl_bank u0 (.*);

    function automatic logic [15:0] built_bits(input int r);
        case (r)
            0: return 16'h0FF3;  1: return 16'h7FFF;  2: return 16'h073F;
            3: return 16'hFFFF;  4: return 16'h7777;  5: return 16'h03FF;
            6: return 16'hFBFF;  7: return 16'hFFFF;  8: return 16'hFFFF;
            9: return 16'hFFFF; 10: return 16'h0037; 11: return 16'h7F77;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a[1:0] == 2'b00 && a < 8'h30) begin
            int r = a >> 2;
            model[r] = ((model[r] & ~d[31:16]) | (d[15:0] & d[31:16])) & built_bits(r);
        end
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic check_reg(input int r, input string req);
        logic [31:0] v;
        do_read(8'(r * 4), v);
        check(v == {16'h0, model[r]}, req, v, {16'h0, model[r]});
    endtask

    task automatic check_outs();
        logic [31:0] act, exp;
        act = {tx_idle, tx_pd, iddq_en, pll_pd};
        exp = {model[0][11:8], model[0][7:4], model[0][1], model[0][0]};
        check(act == exp, "R9 reg0 fields", act, exp);
        act = {pll_div, tx_term, link_rate, ref_div};
        exp = {model[1][14:0], model[2][10:8], model[2][5:4], model[2][3:0]};
        check(act == exp, "R9 reg1/reg2 fields", act, exp);
        exp = 0;
        for (int l = 0; l < 4; l++) exp[3*l +: 3] = model[4][4*l +: 3];
        check({tx_emp, tx_amp_scale} == {model[3], model[5][7:0]} && tx_amp == exp[11:0],
              "R9 lane fields", {tx_emp, tx_amp_scale, tx_amp[7:0]},
              {model[3], model[5][7:0], exp[7:0]});
        act = {tx_mode, ssc_depth, ssc_en, ssc_cnt};
        exp = {model[5][9:8], model[6][15:12], model[6][11], model[6][9:0]};
        check(act == exp, "R9 mode/ssc fields", act, exp);
        check({spare_ctl, pll_ctl_hi} == {model[7], model[8]} && tx_ctl == model[9],
              "R9 full words", {spare_ctl, tx_ctl}, {model[7], model[9]});
        act = {aux_rcv_pd_sel, aux_drv_pd_sel, aux_idle, aux_rcv_pd, aux_drv_pd,
               aux_vcm, aux_mode, aux_amp_scale, aux_amp, aux_term};
        exp = {model[10][5], model[10][4], model[10][2], model[10][1], model[10][0],
               model[11][14:12], model[11][11:10], model[11][9:8], model[11][6:4], model[11][2:0]};
        check(act == exp, "R9 aux fields", act, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int r = 0; r < 12; r++) model[r] = (r == 0) ? 16'h0FF1 : 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset contents and outputs
        check_outs();
        for (int r = 0; r < 12; r++) check_reg(r, "R1 reset value");

        // R2 / R4 walking single enable bit, ones then zeros
        for (int r = 0; r < 12; r++) begin
            for (int b = 0; b < 16; b++) begin
                do_write(8'(r * 4), {16'h0001 << b, 16'hFFFF});
                check_reg(r, "R2/R4 walk set");
            end
            check_outs();
            for (int b = 0; b < 16; b++) begin
                do_write(8'(r * 4), {16'h0001 << b, 16'h0000});
                check_reg(r, "R2/R4 walk clear");
            end
        end

        // R2 / R3 random data and masks, zero and full masks included
        for (int r = 0; r < 12; r++) begin
            for (int k = 0; k < 24; k++) begin
                logic [15:0] en;
                rng = next_rand(rng);
                en = (k == 0) ? 16'h0 : (k == 1) ? 16'hFFFF : rng[31:16];
                do_write(8'(r * 4), {en, rng[15:0]});
                check_reg(r, (k == 0) ? "R3 zero mask" : "R2 masked write");
                check_outs();
            end
        end

        // R6 / R7 status reads
        pll_ready = 1'b1; phy_status = 16'hA5C3;
        do_read(8'h30, v); check(v == 32'h1, "R6 pll ready high", v, 32'h1);
        do_read(8'h34, v); check(v == 32'hA5C3, "R7 status word", v, 32'hA5C3);
        pll_ready = 1'b0; phy_status = 16'h5A3C;
        do_read(8'h30, v); check(v == 32'h0, "R6 pll ready low", v, 32'h0);
        do_read(8'h34, v); check(v == 32'h5A3C, "R7 status word", v, 32'h5A3C);

        // R8 writes to status, beyond the map and misaligned are ignored
        do_write(8'h30, 32'hFFFF_FFFF);
        do_write(8'h34, 32'hFFFF_FFFF);
        do_write(8'h38, 32'hFFFF_FFFF);
        do_write(8'hFC, 32'hFFFF_FFFF);
        do_write(8'h01, 32'hFFFF_FFFF);
        do_write(8'h2E, 32'hFFFF_FFFF);
        for (int r = 0; r < 12; r++) check_reg(r, "R8 ignored writes");
        check_outs();
        do_read(8'h38, v); check(v == 32'h0, "R8 unmapped read", v, 32'h0);
        do_read(8'h05, v); check(v == 32'h0, "R8 misaligned read", v, 32'h0);
        do_read(8'hFC, v); check(v == 32'h0, "R8 top read", v, 32'h0);

        // R5 read data holds while rd_en is low
        do_read(8'h04, v);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); addr = 8'(i * 4);
            check(rdata == v, "R5 hold", rdata, v);
        end

        // R10 same-cycle read and write returns old contents
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 8'h1C; wdata = {16'hFFFF, ~model[7]};
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(rdata == {16'h0, model[7]}, "R10 read before write", rdata, {16'h0, model[7]});
        model[7] = ~model[7];
        check_reg(7, "R10 write landed");

        // R1 reset again after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int r = 0; r < 12; r++) model[r] = (r == 0) ? 16'h0FF1 : 16'h0000;
        check(rdata == 32'h0, "R1 rdata reset", rdata, 32'h0);
        check_outs();
        for (int r = 0; r < 12; r++) check_reg(r, "R1 reset value");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule